// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block sits between a processor's execute stage and a data memory that is 32 bits wide and addressed by byte. On each request it adds a base register value to a signed 16-bit displacement to form the effective byte address. For stores it works out which of the four byte lanes of the memory word are written, and it spreads the source data across all lanes so that the enabled lanes carry the right bytes. For loads it takes the word the memory returns one cycle later and selects the addressed byte or halfword. It then sign-extends or zero-extends that value to 32 bits.

The numbering of bytes inside a word is fixed at build time by a parameter. In big-endian numbering, byte address 0 of a word is the most significant lane. In little-endian numbering it is the least significant lane. Misaligned halfword and word accesses are only flagged. They never reach memory as writes, and a misaligned load returns zero.

Size codes on `req_size`: `00` is byte, `01` is halfword, and `10` or `11` is word.

Top module: `lsu_aligner`

## Requirements
- R1: `mem_addr` equals `base_addr` plus `addr_ofs` sign-extended to the address width, modulo 2^ADDR_W. It is combinational, in the same cycle as the request.
- R2: A valid byte store (size `00`) drives exactly one bit of `mem_be`. With a = `mem_addr[1:0]`, that bit is lane a in little-endian and lane 3-a in big-endian (lane k = bits 8k+7..8k). `mem_wdata` holds `store_src[7:0]` in all four lanes.
- R3: A valid aligned halfword store (size `01`) enables lanes 1:0 (`4'b0011`) or lanes 3:2 (`4'b1100`). The upper pair is chosen when `mem_addr[1]` XOR big-endian is 1. `mem_wdata` is `{store_src[15:0], store_src[15:0]}`.
- R4: A valid aligned word store (size `1x`) gives `mem_be = 4'b1111` and `mem_wdata = store_src`.
- R5: `misaligned` is 1 in the request cycle exactly when `req_valid` is 1 and either the size is halfword with `mem_addr[0]=1`, or the size is word with `mem_addr[1:0]` not zero. Byte accesses are never misaligned. While `misaligned` is 1, `mem_we` is 0 and `mem_be` is 0.
- R6: `mem_we` is 1 only for a valid, aligned store. In every other cycle (loads, idle), `mem_we` is 0 and `mem_be` is 0.
- R7: `load_data` is computed from `rdata_in` of the cycle after a valid load request. It uses the address bits, size and signedness captured at that request. The captured control holds until the next valid load, so `load_data` keeps following `rdata_in`.
- R8: Signed byte and halfword loads (`req_unsigned=0`) sign-extend the selected value to 32 bits. The selected byte comes from the lane given in R2, and the selected halfword comes from the lane pair given in R3.
- R9: Unsigned byte and halfword loads zero-extend the selected value to 32 bits.
- R10: An aligned word load passes `rdata_in` through unchanged in both byte orders.
- R11: A misaligned load gives `load_data = 0` in the following cycle.
- R12: After reset, the captured load control is an aligned word with offset 0, so `load_data` equals `rdata_in`, and `mem_we`/`mem_be` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_unsigned | input | 1 | Zero-extend byte/halfword loads |
| base_addr | input | ADDR_W | Base register value |
| addr_ofs | input | OFS_W | Signed displacement |
| store_src | input | 32 | Store source register |
| mem_addr | output | ADDR_W | Effective byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| misaligned | output | 1 | Alignment error for this request |
| rdata_in | input | 32 | Word read from memory, one cycle after request |
| load_data | output | 32 | Extracted and extended load result |

## Verification
The address, lane enables, write data, write strobe and alignment flag are all due in the request cycle itself. The load result is due one cycle later, formed from the memory word presented in that later cycle. The bench drives every input on the falling edge and compares one time unit later. Its reference model keeps the last valid load's control in a one-entry holding slot, which it updates only at the rising edge that closes the request cycle, so each load result is compared in exactly the cycle it is due. Both byte orders run side by side on the same stimulus, and their expected lanes and values are rebuilt from byte-address arithmetic.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int LSU_DATA_W = 32;
  localparam int LSU_LANES  = LSU_DATA_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic [1:0] lo;
    logic [1:0] size;
    logic       uns;
    logic       bad;
  } ld_ctl_t;

  // physical lane holding the byte at low address bits lo
  function automatic logic [1:0] lane_of(input logic [1:0] lo, input logic big);
    return big ? ~lo : lo;
  endfunction

  function automatic logic is_misaligned(input logic [1:0] sz, input logic [1:0] lo);
    if (sz[1])      return lo != 2'b00;
    else if (sz[0]) return lo[0];
    else            return 1'b0;
  endfunction

  function automatic logic [LSU_LANES-1:0] store_mask(input logic [1:0] sz,
                                                      input logic [1:0] lo,
                                                      input logic big);
    logic [LSU_LANES-1:0] m;
    if (sz[1])      m = 4'b1111;
    else if (sz[0]) m = (lo[1] ^ big) ? 4'b1100 : 4'b0011;
    else            m = 4'b0001 << lane_of(lo, big);
    return m;
  endfunction

  function automatic logic [LSU_DATA_W-1:0] pick_load(input logic [LSU_DATA_W-1:0] rd,
                                                      input ld_ctl_t ctl,
                                                      input logic big);
    logic [7:0]  b;
    logic [15:0] h;
    logic [1:0]  ln;
    ln = lane_of(ctl.lo, big);
    b  = rd[{ln, 3'b000} +: 8];
    h  = (ctl.lo[1] ^ big) ? rd[31:16] : rd[15:0];
    if (ctl.bad)        return '0;
    else if (ctl.size[1]) return rd;
    else if (ctl.size[0]) return ctl.uns ? {16'h0000, h} : {{16{h[15]}}, h};
    else                  return ctl.uns ? {24'h000000, b} : {{24{b[7]}}, b};
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              req_valid,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFS_W-1:0]  addr_ofs,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              bad_align
);
  import lsu_pkg::*;

  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  assign ofs_ext   = {{EXT_W{addr_ofs[OFS_W-1]}}, addr_ofs};
  assign eff_addr  = base_addr + ofs_ext;
  assign bad_align = req_valid && is_misaligned(req_size, eff_addr[1:0]);

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic                                 req_store,
  input  logic [1:0]                           req_size,
  input  logic [1:0]                           addr_lo,
  input  logic                                 bad_align,
  input  logic [lsu_pkg::LSU_DATA_W-1:0]       store_src,
  output logic                                 mem_we,
  output logic [lsu_pkg::LSU_LANES-1:0]        mem_be,
  output logic [lsu_pkg::LSU_DATA_W-1:0]       mem_wdata
);
  import lsu_pkg::*;

  logic write_go;

  assign write_go = req_valid && req_store && !bad_align;
  assign mem_we   = write_go;
  assign mem_be   = write_go ? store_mask(req_size, addr_lo, BIG_ENDIAN) : '0;

  for (genvar g = 0; g < LSU_LANES; g++) begin : g_lane
    always_comb begin
      if (req_size[1])      mem_wdata[8*g +: 8] = store_src[8*g +: 8];
      else if (req_size[0]) mem_wdata[8*g +: 8] = store_src[8*(g%2) +: 8];
      else                  mem_wdata[8*g +: 8] = store_src[7:0];
    end
  end

  AST_NO_WRITE_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_align |-> (mem_be == '0 && !mem_we)); // R5

  AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> (mem_be == '0 && !mem_we)); // R6

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == SZ_BYTE) |-> $countones(mem_be) == 1); // R2

  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && req_size == SZ_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100)); // R3

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_store,
  input  logic [1:0]                     req_size,
  input  logic                           req_unsigned,
  input  logic [1:0]                     addr_lo,
  input  logic                           bad_align,
  input  logic [lsu_pkg::LSU_DATA_W-1:0] rdata_in,
  output logic [lsu_pkg::LSU_DATA_W-1:0] load_data
);
  import lsu_pkg::*;

  ld_ctl_t ctl_q;
  logic    load_req;

  assign load_req = req_valid && !req_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{lo: 2'b00, size: SZ_WORD, uns: 1'b0, bad: 1'b0};
    end else if (load_req) begin
      ctl_q <= '{lo: addr_lo, size: req_size, uns: req_unsigned, bad: bad_align};
    end
  end

  assign load_data = pick_load(rdata_in, ctl_q, BIG_ENDIAN);

  AST_SEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !bad_align && req_size == SZ_BYTE && !req_unsigned)
      |=> load_data[31:8] == {24{load_data[7]}}); // R8

  AST_SEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !bad_align && req_size == SZ_HALF && !req_unsigned)
      |=> load_data[31:16] == {16{load_data[15]}}); // R8

  AST_ZEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && req_size == SZ_BYTE && req_unsigned) |=> load_data[31:8] == '0); // R9

  AST_ZEXT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && req_size == SZ_HALF && req_unsigned) |=> load_data[31:16] == '0); // R9

  AST_BAD_LOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && bad_align) |=> load_data == '0); // R11

  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !bad_align && req_size[1]) |=> load_data == rdata_in); // R10

endmodule

// File: rtl/lsu_aligner.sv
module lsu_aligner #(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 16,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFS_W-1:0]  addr_ofs,
  input  logic [31:0]       store_src,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  output logic              misaligned,
  input  logic [31:0]       rdata_in,
  output logic [31:0]       load_data
);

  logic [ADDR_W-1:0] eff_addr;
  logic              bad_align;
  logic [1:0]        addr_lo;

  assign addr_lo    = eff_addr[1:0];
  assign mem_addr   = eff_addr;
  assign misaligned = bad_align;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .req_valid (req_valid),
    .req_size  (req_size),
    .base_addr (base_addr),
    .addr_ofs  (addr_ofs),
    .eff_addr  (eff_addr),
    .bad_align (bad_align)
  );

  lsu_store_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .req_size  (req_size),
    .addr_lo   (addr_lo),
    .bad_align (bad_align),
    .store_src (store_src),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata)
  );

  lsu_load_extract #(.BIG_ENDIAN(BIG_ENDIAN)) u_load (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_store    (req_store),
    .req_size     (req_size),
    .req_unsigned (req_unsigned),
    .addr_lo      (addr_lo),
    .bad_align    (bad_align),
    .rdata_in     (rdata_in),
    .load_data    (load_data)
  );

  AST_BYTE_NEVER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b00) |-> !misaligned); // R5

endmodule

// File: tb/lsu_aligner_bench.sv
module lsu_aligner_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_unsigned = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] addr_ofs = '0;
  logic [31:0] store_src = '0;
  logic [31:0] rdata_in = '0;

  logic [31:0] le_addr, be_addr, le_wdata, be_wdata, le_ld, be_ld;
  logic [3:0]  le_be, be_be;
  logic        le_we, be_we, le_bad, be_bad;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // one-entry holding slot of the last valid load
  int  p_lo   = 0;
  int  p_n    = 4;
  bit  p_uns  = 1'b0;
  bit  p_bad  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_aligner #(.BIG_ENDIAN(1'b0)) u_lsu_aligner (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .addr_ofs(addr_ofs), .store_src(store_src), .mem_addr(le_addr), .mem_we(le_we),
    .mem_be(le_be), .mem_wdata(le_wdata), .misaligned(le_bad), .rdata_in(rdata_in),
    .load_data(le_ld));

  lsu_aligner #(.BIG_ENDIAN(1'b1)) u_lsu_aligner_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .base_addr(base_addr),
    .addr_ofs(addr_ofs), .store_src(store_src), .mem_addr(be_addr), .mem_we(be_we),
    .mem_be(be_be), .mem_wdata(be_wdata), .misaligned(be_bad), .rdata_in(rdata_in),
    .load_data(be_ld));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return sz[1] ? 4 : (sz[0] ? 2 : 1);
  endfunction

  function automatic int lane_for(input int byte_addr, input bit big);
    return big ? 3 - (byte_addr % 4) : (byte_addr % 4);
  endfunction

  function automatic logic [3:0] exp_mask(input int lo, input int n, input bit big);
    logic [3:0] m = '0;
    for (int i = lo; i < lo + n; i++) m[lane_for(i, big)] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] rd, input int lo, input int n,
                                           input bit uns, input bit bad, input bit big);
    logic [31:0] v = '0;
    logic [7:0]  b;
    if (bad) return '0;
    for (int k = 0; k < n; k++) begin
      b = rd[8*lane_for(lo + k, big) +: 8];
      if (big) v = (v << 8) | 32'(b);
      else     v = v | (32'(b) << (8*k));
    end
    if (!uns && n < 4 && v[8*n-1]) v = v | (32'hFFFF_FFFF << (8*n));
    return v;
  endfunction

  task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit uns,
                      input logic [31:0] base, input logic [15:0] ofs,
                      input logic [31:0] src, input logic [31:0] rd);
    logic [31:0] ea;
    int  lo, n;
    bit  bad;
    logic [3:0] mle, mbe;
    logic [31:0] wd;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_unsigned = uns;
    base_addr = base; addr_ofs = ofs; store_src = src; rdata_in = rd;
    #1;
    ea  = base + {{16{ofs[15]}}, ofs};
    lo  = int'(ea[1:0]);
    n   = nbytes(sz);
    bad = v && ((n == 4 && lo != 0) || (n == 2 && lo[0]));
    check("R1 le addr", le_addr, ea);
    check("R1 be addr", be_addr, ea);
    check("R5 le flag", {31'b0, le_bad}, {31'b0, bad});
    check("R5 be flag", {31'b0, be_bad}, {31'b0, bad});
    if (v && st && !bad) begin
      mle = exp_mask(lo, n, 1'b0);
      mbe = exp_mask(lo, n, 1'b1);
      wd  = (n == 4) ? src : (n == 2) ? {2{src[15:0]}} : {4{src[7:0]}};
      check(n == 1 ? "R2 le mask" : n == 2 ? "R3 le mask" : "R4 le mask", {28'b0, le_be}, {28'b0, mle});
      check(n == 1 ? "R2 be mask" : n == 2 ? "R3 be mask" : "R4 be mask", {28'b0, be_be}, {28'b0, mbe});
      check("R6 le we", {31'b0, le_we}, 32'd1);
      check("R6 be we", {31'b0, be_we}, 32'd1);
      check(n == 1 ? "R2 le data" : n == 2 ? "R3 le data" : "R4 le data", le_wdata, wd);
      check(n == 1 ? "R2 be data" : n == 2 ? "R3 be data" : "R4 be data", be_wdata, wd);
    end else begin
      check("R6 le quiet", {27'b0, le_we, le_be}, '0);
      check("R6 be quiet", {27'b0, be_we, be_be}, '0);
    end
    // load result for the request captured in an earlier cycle
    check(p_bad ? "R11 le load" : (p_n == 4 ? "R10 le load" : (p_uns ? "R9 le load" : "R8 le load")),
          le_ld, exp_load(rd, p_lo, p_n, p_uns, p_bad, 1'b0));
    check(p_bad ? "R11 be load" : (p_n == 4 ? "R10 be load" : (p_uns ? "R9 be load" : "R8 be load")),
          be_ld, exp_load(rd, p_lo, p_n, p_uns, p_bad, 1'b1));
    @(posedge clk);
    if (v && !st) begin
      p_lo = lo; p_n = n; p_uns = uns; p_bad = bad;   // R7 capture
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    rdata_in = 32'h8899_AABB;
    repeat (2) @(negedge clk);
    #1;
    check("R12 le load", le_ld, 32'h8899_AABB);
    check("R12 be load", be_ld, 32'h8899_AABB);
    check("R12 quiet", {26'b0, le_we, be_we, le_be | be_be}, '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0, 32'h1234_5678);

    // directed sweep: every size code, low address, direction and signedness
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        for (int d = 0; d < 2; d++)
          for (int u = 0; u < 2; u++) begin
            step(1'b1, d[0], s[1:0], u[0], 32'h0000_1000, 16'(a), 32'hC3A5_96F0,
                 32'h80FF_7F01);
            step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0, 32'hF1E2_D3C4);
          end

    // negative displacements and address wrap (R1)
    step(1'b1, 1'b1, 2'b01, 1'b0, 32'h0000_0004, 16'hFFFE, 32'h0000_BEEF, 32'h0);
    step(1'b1, 1'b0, 2'b10, 1'b0, 32'h0000_0000, 16'hFFFC, 32'h0, 32'h0);
    step(1'b1, 1'b0, 2'b00, 1'b0, 32'hFFFF_FFFF, 16'h0001, 32'h0, 32'h0102_8384);
    step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0, 32'hFEDC_BA98);

    // back-to-back loads and held control across idle cycles (R7)
    step(1'b1, 1'b0, 2'b01, 1'b0, 32'h0000_2002, 16'h0000, 32'h0, 32'h0);
    step(1'b1, 1'b0, 2'b00, 1'b1, 32'h0000_2003, 16'h0000, 32'h0, 32'h8001_7FFE);
    step(1'b1, 1'b1, 2'b10, 1'b0, 32'h0000_2000, 16'h0000, 32'hDEAD_BEEF, 32'h00C0_FFEE);
    step(1'b0, 1'b0, 2'b00, 1'b0, 32'h0, 16'h0, 32'h0, 32'h9ABC_DEF0);

    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
           $urandom_range(0, 1) == 1, $urandom, 16'($urandom), $urandom, $urandom);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule